// File: doc/BRIEF.md
# Alternate-Mark-Inversion Test Pattern Generator

This block produces a repeating three-level line pattern for testing cables and line receivers. Every period of the bit clock is one bit slot. A one (a "mark") is sent as a pulse whose sign is the opposite of the previous mark. A zero is sent as no pulse at all. The block does not drive the line. It drives two enables, one for a positive pulse and one for a negative pulse, and an external three-level stage turns them into the line signal. The intended bit rate is 8.448 Mbit/s.

A two-bit mode input chooses one of three repeating bit sequences. A strobe stage removes zero, one or two clock slots from each pattern cycle to form the sequence. The strobe decides each slot on the falling clock edge, and a new decision is made only once the current one has run out. A toggle that flips on every surviving mark sets its sign. Both the mark and its sign are fixed on the falling edge, so the polarity select has settled before the rising edge releases the pulse. Each pulse returns to zero and lasts only for the high half of the clock.

Top module: `ami_pattern_gen`

## Requirements
- R1: While reset is low, all three outputs are 0. After reset, the first mark is positive.
- R2: Mode code 0 marks every slot, giving the sequence 1-1-1-1.
- R3: Mode code 1 marks every second slot, giving 1-0-1-0. The first slot of each cycle is the mark.
- R4: Mode code 2 marks every third slot, giving 1-0-0-1-0-0. The first slot of each cycle is the mark.
- R5: Successive marks alternate in sign, and zero slots between them do not change the alternation.
- R6: In a zero slot, both pulse enables stay low.
- R7: An enable can be high only while the clock is high. Both enables are low during the low half of every slot.
- R8: The positive and negative enables are never high at the same time.
- R9: A change of mode code takes effect at the first slot of the next pattern cycle. The sign alternation carries across the change.
- R10: Mode code 3 is reserved. It produces only zero slots, and its cycle is one slot long.
- R11: The debug output `bit_dbg` is 1 for the whole of a mark slot and 0 for the whole of a zero slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one period per bit slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pattern code: 0 all marks, 1 every second, 2 every third, 3 reserved (zeros) |
| pos_en | output | 1 | Positive pulse enable, high only during the high clock half |
| neg_en | output | 1 | Negative pulse enable, high only during the high clock half |
| bit_dbg | output | 1 | Bit value of the current slot, held for the whole slot |

## Verification
The all-marks pattern shows that the sign flips on every slot. The every-second and every-third patterns show that zero slots are blanked and do not advance the sign. The reserved code, selected part-way through a cycle, shows that the current cycle finishes before the change. A switch from every-third to all-marks shows that the zero slots already due are still sent, and that the next mark takes the sign that follows the last mark. Every slot is sampled in both clock halves, which separates a return-to-zero fault from a slot-timing fault.

// File: rtl/ami_pkg.sv
`timescale 1ns/1ps
package ami_pkg;
  localparam int MODE_W  = 2;
  localparam int MAX_LEN = 3;
  localparam int PHASE_W = $clog2(MAX_LEN);

  typedef enum logic [MODE_W-1:0] {
    PAT_ALL   = 2'd0,
    PAT_ALT   = 2'd1,
    PAT_THIRD = 2'd2,
    PAT_IDLE  = 2'd3
  } pat_e;

  // Index of the last slot of a pattern cycle (cycle length minus one).
  function automatic logic [PHASE_W-1:0] last_phase(pat_e m);
    case (m)
      PAT_ALT:   last_phase = PHASE_W'(1);
      PAT_THIRD: last_phase = PHASE_W'(2);
      default:   last_phase = '0;
    endcase
  endfunction

  // A slot carries a mark only at the start of a cycle of a live pattern.
  function automatic logic slot_marks(pat_e m, logic start);
    slot_marks = start && (m != PAT_IDLE);
  endfunction
endpackage

// File: rtl/ami_strobe.sv
`timescale 1ns/1ps
module ami_strobe
  import ami_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pat_e mode_sel,
  output logic mark_d,
  output logic mark_q,
  output pat_e act_q,
  output logic cycle_start
);
  logic [PHASE_W-1:0] left_q;
  logic [PHASE_W-1:0] left_d;
  pat_e               eff_mode;

  always_comb begin
    cycle_start = (left_q == '0);
    eff_mode    = cycle_start ? mode_sel : act_q;
    mark_d      = slot_marks(eff_mode, cycle_start);
    left_d      = cycle_start ? last_phase(eff_mode) : left_q - 1'b1;
  end

  // Slot decisions are taken on the falling edge, ahead of the pulse half.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      act_q  <= PAT_IDLE;
      mark_q <= 1'b0;
    end else begin
      left_q <= left_d;
      act_q  <= eff_mode;
      mark_q <= mark_d;
    end
  end

  p_reserved_r10: assert property (@(negedge clk) disable iff (!rst_n)
    (cycle_start && mode_sel == PAT_IDLE) |=> !mark_q);
  p_spacing_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (mark_q && act_q != PAT_ALL) |=> !mark_q);
  p_third_gap_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (mark_q && act_q == PAT_THIRD) |=> ##1 !mark_q);
endmodule

// File: rtl/ami_polarity.sv
`timescale 1ns/1ps
module ami_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_d,
  output logic slot_neg_q
);
  logic pol_q; // sign to give the next mark: 0 positive, 1 negative

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q      <= 1'b0;
      slot_neg_q <= 1'b0;
    end else if (mark_d) begin
      slot_neg_q <= pol_q;
      pol_q      <= ~pol_q;
    end
  end

  p_sign_hold_r5: assert property (@(negedge clk) disable iff (!rst_n)
    !mark_d |=> $stable(pol_q));
endmodule

// File: rtl/ami_rz_gate.sv
`timescale 1ns/1ps
module ami_rz_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_q,
  input  logic slot_neg_q,
  output logic pos_en,
  output logic neg_en,
  output logic bit_dbg
);
  always_comb begin
    pos_en  = clk & mark_q & ~slot_neg_q;
    neg_en  = clk & mark_q &  slot_neg_q;
    bit_dbg = mark_q;
  end

  always_comb begin
    if (rst_n === 1'b1) begin
      p_exclusive_r8: assert (!(pos_en && neg_en));
    end
  end

  p_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_en && !neg_en);
endmodule

// File: rtl/ami_pattern_gen.sv
`timescale 1ns/1ps
module ami_pattern_gen
  import ami_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  output logic              pos_en,
  output logic              neg_en,
  output logic              bit_dbg
);
  logic mark_d;
  logic mark_q;
  logic slot_neg_q;
  logic cycle_start;
  pat_e act_mode;

  ami_strobe u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (pat_e'(mode)),
    .mark_d      (mark_d),
    .mark_q      (mark_q),
    .act_q       (act_mode),
    .cycle_start (cycle_start)
  );

  ami_polarity u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_d     (mark_d),
    .slot_neg_q (slot_neg_q)
  );

  ami_rz_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_q     (mark_q),
    .slot_neg_q (slot_neg_q),
    .pos_en     (pos_en),
    .neg_en     (neg_en),
    .bit_dbg    (bit_dbg)
  );

  // Sign of the most recent mark; starts as negative so the first must be positive.
  logic last_sign_q;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      last_sign_q <= 1'b1;
    else if (mark_q) last_sign_q <= slot_neg_q;
  end

  p_alternate_r5: assert property (@(negedge clk) disable iff (!rst_n)
    mark_q |-> (slot_neg_q != last_sign_q));
  p_mode_hold_r9: assert property (@(negedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(act_mode));
endmodule

// File: tb/tb_ami_pattern_gen.sv
`timescale 1ns/1ps
module tb_ami_pattern_gen;
  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode  = 2'd0;
  logic       pos_en, neg_en, bit_dbg;

  int n_chk = 0;
  int n_bad = 0;

  // independent model state
  int         m_idx = 0;
  logic [1:0] m_act = 2'd0;
  logic       m_pol = 1'b0;

  always #2.5 clk = ~clk;

  ami_pattern_gen dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .pos_en  (pos_en),
    .neg_en  (neg_en),
    .bit_dbg (bit_dbg)
  );

  function automatic int cyc_len(logic [1:0] m);
    if (m == 2'd1) return 2;
    if (m == 2'd2) return 3;
    return 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // One bit slot: check the low half, then the high half.
  task automatic slot(string req);
    logic e_mark, e_neg;
    @(negedge clk);
    if (m_idx == 0) m_act = mode;
    e_mark = (m_idx == 0) && (m_act != 2'd3);
    e_neg  = m_pol;
    m_idx  = (m_idx + 1) % cyc_len(m_act);
    #1;
    chk("R7", pos_en | neg_en, 1'b0);
    @(posedge clk);
    #1;
    chk(req, pos_en, e_mark & ~e_neg);
    chk(req, neg_en, e_mark &  e_neg);
    chk("R8", pos_en & neg_en, 1'b0);
    chk("R11", bit_dbg, e_mark);
    if (!e_mark) chk("R6", pos_en | neg_en, 1'b0);
    if (e_mark) m_pol = ~m_pol;
  endtask

  task automatic t_reset(logic [1:0] m);
    rst_n = 1'b0;
    mode  = m;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", pos_en, 1'b0);
    chk("R1", neg_en, 1'b0);
    chk("R1", bit_dbg, 1'b0);
    rst_n = 1'b1;
    m_idx = 0;
    m_pol = 1'b0;
  endtask

  task automatic t_all_marks();
    t_reset(2'd0);
    slot("R1");           // first mark must be positive
    chk("R1", pos_en, 1'b1);
    repeat (7) slot("R2");
  endtask

  task automatic t_alternate();
    t_reset(2'd1);
    repeat (10) slot("R3");
    repeat (4)  slot("R5");
  endtask

  task automatic t_third();
    t_reset(2'd2);
    repeat (12) slot("R4");
  endtask

  task automatic t_reserved();
    t_reset(2'd1);
    repeat (3) slot("R3");  // mid-cycle of the alternating pattern
    mode = 2'd3;
    repeat (6) slot("R10");
    mode = 2'd0;
    repeat (4) slot("R9");
  endtask

  task automatic t_switch();
    t_reset(2'd2);
    repeat (4) slot("R4");  // one slot into the second cycle
    mode = 2'd0;
    slot("R9");             // still a zero slot of the old cycle
    chk("R9", bit_dbg, 1'b0);
    slot("R9");
    repeat (5) slot("R9");  // all marks, sign continues
    mode = 2'd1;
    repeat (6) slot("R5");
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_all_marks();
    t_alternate();
    t_third();
    t_reserved();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule